// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit turns a segment selector and a 16-bit offset into a physical byte address. It works in two modes. In real mode the 16-bit segment value is multiplied by sixteen and added to the offset, which gives a 20-bit address. Every segment value is valid and nothing is checked. In protected mode the upper thirteen selector bits pick an entry in a small on-chip descriptor table. The entry's 24-bit base is added to the offset, after checks for a null selector, a missing entry and an offset past the entry's limit.

Descriptors are loaded through a write port, one entry per cycle. A request is offered with a single valid strobe. Its response, which carries the address and a 2-bit fault code, appears exactly one cycle later. The mode input is registered, so a change of mode applies to requests from the following cycle on.

Top module: `seg_xlat_unit`

## Requirements
- R1: In real mode the response address is (segment × 16 + offset) modulo 2^20, zero-extended to 24 bits, with fault code 0.
- R2: Real mode does no checks: every segment value translates, and distinct segment:offset pairs that name the same byte (for example 0x1234:0x0005 and 0x1230:0x0045) both return that byte's address without a fault.
- R3: In protected mode the table index is selector bits [15:3], and selector bits [2:0] are ignored. The address is (entry base + offset) modulo 2^24, with fault code 0.
- R4: In protected mode an offset greater than the entry's 16-bit limit gives fault code 3 and address 0. An offset equal to the limit translates normally.
- R5: In protected mode an entry whose present bit is clear, or an index at or beyond the table depth, gives fault code 2 and address 0.
- R6: In protected mode index 0 (the null selector) gives fault code 1 and address 0, whatever the table holds.
- R7: A request accepted at a clock edge produces a response with valid high in the next cycle. In a cycle with no request the response valid, address and fault are all 0.
- R8: Reset (synchronous, active low) clears the response outputs, selects real mode and marks every table entry not present.
- R9: The mode input (1 = protected) is sampled at each clock edge and governs requests from the next cycle on. A request presented in the same cycle as a mode change uses the old mode.
- R10: A table write takes effect at the clock edge. A request in the same cycle reads the entry's previous contents. A write whose index is at or beyond the table depth changes nothing.
- R11: Faults are prioritised: null (1) over not-present (2) over limit (3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| prot_mode_i | input | 1 | Mode select, 1 = protected, registered |
| dt_we_i | input | 1 | Descriptor write strobe |
| dt_widx_i | input | 13 | Descriptor index to write |
| dt_base_i | input | 24 | Base address to write |
| dt_limit_i | input | 16 | Limit to write |
| dt_present_i | input | 1 | Present bit to write |
| req_valid_i | input | 1 | Translation request strobe |
| req_sel_i | input | 16 | Segment value (real) or selector (protected) |
| req_off_i | input | 16 | Offset within the segment |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_addr_o | output | 24 | Physical address, 0 on fault |
| rsp_fault_o | output | 2 | 0 none, 1 null, 2 not present, 3 limit |

## Verification
The bench uses the default parameters: a 16-entry table with a 24-bit base and a 16-bit limit. A depth that small lets selectors with indices 16 and above reach the out-of-table fault, and lets writes to such indices be shown to have no effect. A base near the top of the 24-bit space brings the protected-mode wrap within reach, and segment 0xFFFF with offset 0xFFFF exercises the 20-bit wrap. Mode switches, same-cycle write-and-read and a reset in the middle of the run are driven directly. Several hundred random cycles follow, each compared with a behavioural model.

// File: rtl/seg_xlat_pkg.sv
// Shared fault encoding and fixed field widths for the segment translation unit.
// Assumes the selector index occupies bits [15:3] of a 16-bit selector.
package seg_xlat_pkg;
    localparam int SEL_IDX_W = 13;
    localparam int SEL_IDX_LSB = 3;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_NULL    = 2'd1,
        FLT_NOTPRES = 2'd2,
        FLT_LIMIT   = 2'd3
    } fault_e;
endpackage

// File: rtl/seg_desc_table.sv
// Descriptor storage: DEPTH entries of base, limit and present bit.
// Has a single write port and one combinational read port. Assumes the read
// returns the pre-write contents when the same entry is written in that cycle.
module seg_desc_table #(
    parameter int DEPTH  = 16,
    parameter int IDX_W  = 13,
    parameter int BASE_W = 24,
    parameter int LIM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BASE_W-1:0] wr_base,
    input  logic [LIM_W-1:0]  wr_limit,
    input  logic              wr_pres,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BASE_W-1:0] rd_base,
    output logic [LIM_W-1:0]  rd_limit,
    output logic              rd_pres,
    output logic              rd_in_range
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [BASE_W-1:0] base_q [DEPTH];
    logic [LIM_W-1:0]  lim_q  [DEPTH];
    logic [DEPTH-1:0]  pres_q;
    logic              wr_in_range;

    assign wr_in_range = int'(wr_idx) < DEPTH;
    assign rd_in_range = int'(rd_idx) < DEPTH;

    // Load one entry per cycle; reset marks all entries absent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pres_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                base_q[i] <= '0;
                lim_q[i]  <= '0;
            end
        end else if (wr_en && wr_in_range) begin
            base_q[wr_idx[AW-1:0]] <= wr_base;
            lim_q[wr_idx[AW-1:0]]  <= wr_limit;
            pres_q[wr_idx[AW-1:0]] <= wr_pres;
        end
    end

    // Read the addressed entry; out-of-range reads look absent.
    always_comb begin
        rd_base  = base_q[rd_idx[AW-1:0]];
        rd_limit = lim_q[rd_idx[AW-1:0]];
        rd_pres  = rd_in_range && pres_q[rd_idx[AW-1:0]];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && wr_en && wr_in_range |=> pres_q[$past(wr_idx[AW-1:0])] == $past(wr_pres)); // R10
    AST_FAR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && wr_en && !wr_in_range |=> $stable(pres_q)); // R10
endmodule

// File: rtl/seg_real_path.sv
// Real-mode adder: segment shifted left by SHIFT bits plus offset.
// The sum wraps at SEG_W+SHIFT bits and is zero-extended to OUT_W.
module seg_real_path #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    parameter int OUT_W = 24
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [OUT_W-1:0] addr
);
    localparam int RADDR_W = SEG_W + SHIFT;

    logic [RADDR_W-1:0] sum;

    // Shift-and-add with no carry kept beyond the top address bit.
    always_comb begin
        sum  = {seg, {SHIFT{1'b0}}} + RADDR_W'(off);
        addr = OUT_W'(sum);
    end
endmodule

// File: rtl/seg_prot_path.sv
// Protected-mode checks and adder. Fault priority: null, then not present,
// then limit. The address is forced to zero on any fault.
module seg_prot_path
    import seg_xlat_pkg::*;
#(
    parameter int IDX_W  = 13,
    parameter int OFF_W  = 16,
    parameter int BASE_W = 24,
    parameter int LIM_W  = 16
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [OFF_W-1:0]  off,
    input  logic [BASE_W-1:0] base,
    input  logic [LIM_W-1:0]  limit,
    input  logic              pres,
    input  logic              in_range,
    output logic [BASE_W-1:0] addr,
    output fault_e            fault
);
    // Classify the access and form the base-plus-offset address.
    always_comb begin
        addr = '0;
        if (idx == '0)                  fault = FLT_NULL;
        else if (!in_range || !pres)    fault = FLT_NOTPRES;
        else if (LIM_W'(off) > limit)   fault = FLT_LIMIT;
        else begin
            fault = FLT_NONE;
            addr  = base + BASE_W'(off);
        end
    end
endmodule

// File: rtl/seg_xlat_unit.sv
// Top of the segment translation unit. Registers the mode and the response;
// a request sampled at one edge yields its response after that edge.
// Assumes requests arrive at most one per cycle with no back-pressure.
module seg_xlat_unit
    import seg_xlat_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int SEL_W   = 16,
    parameter int OFF_W   = 16,
    parameter int SHIFT   = 4,
    parameter int PHYS_W  = 24,
    parameter int LIM_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 prot_mode_i,
    input  logic                 dt_we_i,
    input  logic [SEL_IDX_W-1:0] dt_widx_i,
    input  logic [PHYS_W-1:0]    dt_base_i,
    input  logic [LIM_W-1:0]     dt_limit_i,
    input  logic                 dt_present_i,
    input  logic                 req_valid_i,
    input  logic [SEL_W-1:0]     req_sel_i,
    input  logic [OFF_W-1:0]     req_off_i,
    output logic                 rsp_valid_o,
    output logic [PHYS_W-1:0]    rsp_addr_o,
    output logic [1:0]           rsp_fault_o
);
    localparam int RADDR_W = SEL_W + SHIFT;

    logic                 mode_q;
    logic [SEL_IDX_W-1:0] sel_idx;
    logic [PHYS_W-1:0]    real_addr;
    logic [PHYS_W-1:0]    prot_addr;
    fault_e               prot_fault;
    logic [PHYS_W-1:0]    ent_base;
    logic [LIM_W-1:0]     ent_limit;
    logic                 ent_pres;
    logic                 ent_in_range;

    assign sel_idx = req_sel_i[SEL_IDX_LSB +: SEL_IDX_W];

    seg_desc_table #(
        .DEPTH(DEPTH), .IDX_W(SEL_IDX_W), .BASE_W(PHYS_W), .LIM_W(LIM_W)
    ) table_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(dt_we_i), .wr_idx(dt_widx_i), .wr_base(dt_base_i),
        .wr_limit(dt_limit_i), .wr_pres(dt_present_i),
        .rd_idx(sel_idx), .rd_base(ent_base), .rd_limit(ent_limit),
        .rd_pres(ent_pres), .rd_in_range(ent_in_range)
    );

    seg_real_path #(
        .SEG_W(SEL_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .OUT_W(PHYS_W)
    ) real_i (
        .seg(req_sel_i), .off(req_off_i), .addr(real_addr)
    );

    seg_prot_path #(
        .IDX_W(SEL_IDX_W), .OFF_W(OFF_W), .BASE_W(PHYS_W), .LIM_W(LIM_W)
    ) prot_i (
        .idx(sel_idx), .off(req_off_i), .base(ent_base), .limit(ent_limit),
        .pres(ent_pres), .in_range(ent_in_range),
        .addr(prot_addr), .fault(prot_fault)
    );

    // Track the mode and register one response per accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= 1'b0;
            rsp_valid_o <= 1'b0;
            rsp_addr_o  <= '0;
            rsp_fault_o <= FLT_NONE;
        end else begin
            mode_q      <= prot_mode_i;
            rsp_valid_o <= req_valid_i;
            if (!req_valid_i) begin
                rsp_addr_o  <= '0;
                rsp_fault_o <= FLT_NONE;
            end else if (mode_q) begin
                rsp_addr_o  <= prot_addr;
                rsp_fault_o <= prot_fault;
            end else begin
                rsp_addr_o  <= real_addr;
                rsp_fault_o <= FLT_NONE;
            end
        end
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && req_valid_i |=> rsp_valid_o); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !req_valid_i |=> !rsp_valid_o && rsp_addr_o == '0 && rsp_fault_o == 2'd0); // R7
    AST_REAL_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && req_valid_i && !mode_q |=> rsp_fault_o == 2'd0 && rsp_addr_o[PHYS_W-1:RADDR_W] == '0); // R1
    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault_o != 2'd0 |-> rsp_addr_o == '0); // R4
    AST_NULL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && req_valid_i && mode_q && sel_idx == '0 |=> rsp_fault_o == FLT_NULL); // R6
endmodule

// File: tb/seg_xlat_unit_tb_top.sv
// Self-checking bench with a behavioural reference model compared every cycle.
module seg_xlat_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prot_mode_i = 1'b0;
    logic        dt_we_i = 1'b0;
    logic [12:0] dt_widx_i = '0;
    logic [23:0] dt_base_i = '0;
    logic [15:0] dt_limit_i = '0;
    logic        dt_present_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [15:0] req_sel_i = '0;
    logic [15:0] req_off_i = '0;
    logic        rsp_valid_o;
    logic [23:0] rsp_addr_o;
    logic [1:0]  rsp_fault_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model state
    int  m_base [DEPTH];
    int  m_lim  [DEPTH];
    bit  m_pres [DEPTH];
    bit  m_mode;
    bit  have_exp = 0;
    bit  e_valid;
    int  e_addr;
    int  e_fault;
    string e_tag;

    seg_xlat_unit dut_i (
        .clk(clk), .rst_n(rst_n), .prot_mode_i(prot_mode_i),
        .dt_we_i(dt_we_i), .dt_widx_i(dt_widx_i), .dt_base_i(dt_base_i),
        .dt_limit_i(dt_limit_i), .dt_present_i(dt_present_i),
        .req_valid_i(req_valid_i), .req_sel_i(req_sel_i), .req_off_i(req_off_i),
        .rsp_valid_o(rsp_valid_o), .rsp_addr_o(rsp_addr_o), .rsp_fault_o(rsp_fault_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic compare();
        checks++;
        if (rsp_valid_o !== e_valid || rsp_addr_o !== 24'(e_addr) || rsp_fault_o !== 2'(e_fault)) begin
            errors++;
            $display("FAIL %s: got valid=%0b addr=%06h fault=%0d, expected valid=%0b addr=%06h fault=%0d",
                     e_tag, rsp_valid_o, rsp_addr_o, rsp_fault_o, e_valid, e_addr, e_fault);
        end
    endtask

    // One cycle: check last cycle's prediction, apply inputs, predict, advance model.
    task automatic step(input bit rst, input bit mode, input bit we, input int widx,
                        input int wbase, input int wlim, input bit wpres,
                        input bit rv, input int sel, input int off, input string tag);
        int idx;
        @(negedge clk);
        if (have_exp) compare();
        rst_n = rst; prot_mode_i = mode; dt_we_i = we; dt_widx_i = 13'(widx);
        dt_base_i = 24'(wbase); dt_limit_i = 16'(wlim); dt_present_i = wpres;
        req_valid_i = rv; req_sel_i = 16'(sel); req_off_i = 16'(off);
        e_valid = 0; e_addr = 0; e_fault = 0;
        if (!rst) e_tag = "R8";
        else if (!rv) e_tag = "R7";
        else if (!m_mode) begin
            e_valid = 1; e_tag = "R1";
            e_addr = (((sel & 16'hFFFF) * 16) + (off & 16'hFFFF)) % (1 << 20);
        end else begin
            e_valid = 1;
            idx = (sel & 16'hFFFF) / 8;
            if (idx == 0) begin e_fault = 1; e_tag = "R6"; end
            else if (idx >= DEPTH || !m_pres[idx]) begin e_fault = 2; e_tag = "R5"; end
            else if ((off & 16'hFFFF) > m_lim[idx]) begin e_fault = 3; e_tag = "R4"; end
            else begin
                e_tag = "R3";
                e_addr = (m_base[idx] + (off & 16'hFFFF)) % (1 << 24);
            end
        end
        if (tag != "") e_tag = tag;
        if (!rst) begin
            m_mode = 0;
            for (int i = 0; i < DEPTH; i++) begin m_base[i] = 0; m_lim[i] = 0; m_pres[i] = 0; end
        end else begin
            if (we && widx < DEPTH) begin
                m_base[widx] = wbase & 24'hFFFFFF; m_lim[widx] = wlim & 16'hFFFF; m_pres[widx] = wpres;
            end
            m_mode = mode;
        end
        have_exp = 1;
    endtask

    task automatic req(input bit mode, input int sel, input int off, input string tag);
        step(1, mode, 0, 0, 0, 0, 0, 1, sel, off, tag);
    endtask

    task automatic wr(input bit mode, input int widx, input int wbase, input int wlim, input bit wpres);
        step(1, mode, 1, widx, wbase, wlim, wpres, 0, 0, 0, "R10");
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R8: reset state
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, 0, 0, 1, 8, 0, "R8");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
        // R1 real-mode translation, R8 starts in real mode
        req(0, 16'h1234, 16'h0005, "R8");
        req(0, 16'hFFFF, 16'hFFFF, "R1");
        req(0, 16'h0000, 16'h0000, "R1");
        // R2 aliasing pairs give the same byte, no fault
        req(0, 16'h1230, 16'h0045, "R2");
        req(0, 16'h0008, 16'h0000, "R2");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
        // R10 table loads
        wr(0, 1, 24'h100000, 16'h00FF, 1);
        wr(0, 2, 24'hFFFFF0, 16'hFFFF, 1);
        wr(0, 3, 24'h200000, 16'hFFFF, 0);
        wr(0, 5, 24'h300000, 16'h0000, 0);
        wr(0, 20, 24'h400000, 16'hFFFF, 1);
        // R9 mode change applies from next request
        req(1, 16'h0008, 16'h0010, "R9");
        req(1, 16'h0008, 16'h00FF, "R4");
        req(1, 16'h0008, 16'h0100, "R4");
        req(1, 16'h000F, 16'h0001, "R3");
        req(1, 16'h0010, 16'h0020, "R3");
        req(1, 16'h0018, 16'h0000, "R5");
        req(1, 16'h00A0, 16'h0000, "R10");
        req(1, 16'h0003, 16'h0000, "R6");
        req(1, 16'h0028, 16'h0010, "R11");
        // R10 same-cycle write and read sees old entry
        step(1, 1, 1, 6, 24'h050000, 16'hFFFF, 1, 1, 16'h0030, 16'h0004, "R10");
        req(1, 16'h0030, 16'h0004, "R10");
        // R9 switch back
        req(0, 16'h0030, 16'h0004, "R9");
        req(0, 16'h0030, 16'h0004, "R9");
        // random traffic
        for (int n = 0; n < 600; n++) begin
            bit m; bit we; bit rv;
            m  = ($urandom % 4) != 0;
            we = ($urandom % 5) == 0;
            rv = ($urandom % 4) != 0;
            step(1, m, we, $urandom % 20, $urandom, $urandom % 65536, ($urandom % 4) != 0,
                 rv, (($urandom % 2) != 0) ? ($urandom % 160) : $urandom % 65536,
                 (($urandom % 2) != 0) ? ($urandom % 512) : $urandom % 65536, "");
        end
        // R8 mid-run reset clears table
        wr(1, 1, 24'h111111, 16'hFFFF, 1);
        step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
        step(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
        req(1, 16'h0008, 16'h0000, "R8");
        req(1, 16'h0008, 16'h0000, "R8");
        step(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
        @(negedge clk);
        compare();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule